// File: doc/BRIEF.md
# SDRAM Bank State and Timing Controller

This block follows the state of a single synchronous DRAM bank and keeps the command sequence to that bank within its timing limits. A front end presents one request at a time. The request can be a row open, a read, a write, a read or write that closes the row by itself, an explicit row close, or a burst terminate. The controller checks the request against the bank state and against the configured row-to-column delay, minimum row-active time and precharge time. When the request is legal, the controller issues it in the same cycle. When it is not, the controller holds it with `ready_o` low and emits a no-operation.

Auto-precharge is handled inside the block. A self-closing column command locks the bank until the internal precharge has started and the precharge time has run out. For short bursts, a self-closing column command is accepted only late enough that the internal precharge cannot start before the minimum row-active time has passed. The data path, refresh, power-down and arbitration between banks are left to other blocks.

Top module: `sdram_bank_ctrl`

## Requirements
- R1: After reset, `state_o` is idle (0) and `cmd_o` is NOP (0).
- R2: Command codes are NOP=0, OPEN=1, RD=2, WR=3, RDA=4, WRA=5, CLOSE=6, STOP=7. State codes are idle=0, active=1, burst=2, locked auto-precharge burst=3, precharging=4. OPEN is accepted only when the bank is idle, and the bank is active in the next cycle.
- R3: RD, WR, RDA and WRA are accepted only in the active or burst state. They also need at least `trcd_i` cycles between the OPEN cycle and the column command cycle.
- R4: CLOSE is accepted only in the active or burst state, and at least `tras_i` cycles after OPEN. The bank is idle again `trp_i` cycles after the CLOSE cycle, and OPEN is refused until then.
- R5: After a plain RD or WR in cycle c, the state is burst in cycles c+1 to c+bl-1 and active from c+bl, so the row stays open. A new column command or CLOSE during the burst is accepted and replaces it.
- R6: STOP is accepted only in the burst state and makes the bank active in the next cycle. In any other state STOP is held.
- R7: For RDA in cycle c, the internal precharge starts in cycle s = c + (bl - cl + 1) when bl ≥ cl, and s = c + 1 otherwise. The state is locked from c+1 to s, and idle from s + `trp_i`.
- R8: For WRA in cycle c, the internal precharge starts in cycle s = c + bl, after the last write beat. Idle follows from s + `trp_i`.
- R9: No request other than NOP is accepted while the bank is locked or precharging.
- R10: RDA or WRA is accepted only when the internal precharge start s lies at least `tras_i` cycles after OPEN. This pushes short self-closing bursts later.
- R11: A held request gives `ready_o`=0 and `cmd_o`=NOP. An accepted request gives `ready_o`=1 and `cmd_o` equal to `req_cmd_i`. With `req_valid_i` low, `ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_cmd_i | input | 3 | Requested command code |
| trcd_i | input | TW | Row-to-column delay in cycles |
| tras_i | input | TW | Minimum row-active time in cycles |
| trp_i | input | TW | Precharge time in cycles |
| bl_i | input | BLW | Burst length in beats (at least 1) |
| cl_i | input | CLW | CAS latency in cycles (at least 1) |
| ready_o | output | 1 | Request accepted this cycle |
| cmd_o | output | 3 | Command issued this cycle |
| state_o | output | 3 | Bank state |

## Verification
The bench targets these corner cases:
- A one-beat self-closing read with a long row-active time. A controller that checked only the row-to-column delay would accept it too early, and its precharge would cut the row short.
- A read with CAS latency larger than one. Here the precharge start moves earlier than for a write of the same length, and an off-by-one in either formula shifts the cycle at which the bank returns to idle.
- Requests presented during the locked and precharging phases, including OPEN one cycle before idle. A leaky lock would issue them.
- STOP outside a burst, which must stay held rather than being issued as a stray command.

// File: rtl/sdram_bank_pkg.sv
package sdram_bank_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0, CMD_OPEN = 3'd1, CMD_RD = 3'd2, CMD_WR = 3'd3,
    CMD_RDA = 3'd4, CMD_WRA = 3'd5, CMD_CLOSE = 3'd6, CMD_STOP = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_ACTIVE = 3'd1, ST_BURST = 3'd2,
    ST_LOCKED = 3'd3, ST_PRECHG = 3'd4
  } bank_st_e;
endpackage

// File: rtl/sdram_bank_age.sv
// Saturating count of cycles since the last row open.
module sdram_bank_age #(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          open_i,
  output logic [CW-1:0] age_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               age_o <= '0;
    else if (open_i)           age_o <= CW'(1);
    else if (age_o != '1)      age_o <= age_o + CW'(1);
  end
endmodule

// File: rtl/sdram_bank_rules.sv
// Legality of a request against state and timing; precharge delay for self-closing bursts.
module sdram_bank_rules
  import sdram_bank_pkg::*;
#(
  parameter int TW  = 4,
  parameter int BLW = 4,
  parameter int CLW = 2,
  parameter int CW  = 6
) (
  input  bank_st_e       st_i,
  input  cmd_e           cmd_i,
  input  logic [CW-1:0]  age_i,
  input  logic [TW-1:0]  trcd_i,
  input  logic [TW-1:0]  tras_i,
  input  logic [BLW-1:0] bl_i,
  input  logic [CLW-1:0] cl_i,
  output logic           legal_o,
  output logic [BLW-1:0] ap_delay_o
);
  localparam int DW = CW + 1;

  logic [DW-1:0] bl_x, cl_x, rd_dly, dly_x, reach;
  logic          row_open, rcd_ok, ras_ok, ap_ok;

  always_comb begin
    bl_x   = DW'(bl_i);
    cl_x   = DW'(cl_i);
    rd_dly = (bl_x >= cl_x) ? (bl_x - cl_x + DW'(1)) : DW'(1);
    dly_x  = (cmd_i == CMD_RDA) ? rd_dly : bl_x;
    reach  = DW'(age_i) + dly_x;
    ap_delay_o = BLW'(dly_x);

    row_open = (st_i == ST_ACTIVE) || (st_i == ST_BURST);
    rcd_ok   = age_i >= CW'(trcd_i);
    ras_ok   = age_i >= CW'(tras_i);
    ap_ok    = reach >= DW'(tras_i);

    unique case (cmd_i)
      CMD_NOP:           legal_o = 1'b1;
      CMD_OPEN:          legal_o = (st_i == ST_IDLE);
      CMD_RD, CMD_WR:    legal_o = row_open && rcd_ok;
      CMD_RDA, CMD_WRA:  legal_o = row_open && rcd_ok && ap_ok;
      CMD_CLOSE:         legal_o = row_open && ras_ok;
      CMD_STOP:          legal_o = (st_i == ST_BURST);
      default:           legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sdram_bank_ctrl.sv
module sdram_bank_ctrl
  import sdram_bank_pkg::*;
#(
  parameter int TW  = 4,
  parameter int BLW = 4,
  parameter int CLW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [2:0]     req_cmd_i,
  input  logic [TW-1:0]  trcd_i,
  input  logic [TW-1:0]  tras_i,
  input  logic [TW-1:0]  trp_i,
  input  logic [BLW-1:0] bl_i,
  input  logic [CLW-1:0] cl_i,
  output logic           ready_o,
  output logic [2:0]     cmd_o,
  output logic [2:0]     state_o
);
  localparam int CW = ((TW > BLW) ? TW : BLW) + 2;

  bank_st_e       st_q;
  cmd_e           cmd;
  logic [CW-1:0]  age;
  logic           legal, issue, short_rp;
  logic [BLW-1:0] ap_delay, burst_left_q, ap_left_q;
  logic [TW-1:0]  pre_left_q;

  assign cmd      = cmd_e'(req_cmd_i);
  assign ready_o  = req_valid_i && legal;
  assign issue    = ready_o && (cmd != CMD_NOP);
  assign cmd_o    = ready_o ? req_cmd_i : 3'(CMD_NOP);
  assign state_o  = 3'(st_q);
  assign short_rp = trp_i <= TW'(1);

  sdram_bank_age #(.CW(CW)) i_age (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (issue && cmd == CMD_OPEN),
    .age_o  (age)
  );

  sdram_bank_rules #(.TW(TW), .BLW(BLW), .CLW(CLW), .CW(CW)) i_rules (
    .st_i       (st_q),
    .cmd_i      (cmd),
    .age_i      (age),
    .trcd_i     (trcd_i),
    .tras_i     (tras_i),
    .bl_i       (bl_i),
    .cl_i       (cl_i),
    .legal_o    (legal),
    .ap_delay_o (ap_delay)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      burst_left_q <= '0;
      ap_left_q    <= '0;
      pre_left_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (issue && cmd == CMD_OPEN) st_q <= ST_ACTIVE;
        ST_ACTIVE, ST_BURST: begin
          if (st_q == ST_BURST) begin
            if (burst_left_q <= BLW'(1)) st_q <= ST_ACTIVE;
            burst_left_q <= burst_left_q - BLW'(1);
          end
          if (issue) begin
            unique case (cmd)
              CMD_RD, CMD_WR: begin
                burst_left_q <= bl_i - BLW'(1);
                st_q <= (bl_i > BLW'(1)) ? ST_BURST : ST_ACTIVE;
              end
              CMD_RDA, CMD_WRA: begin
                ap_left_q <= ap_delay;
                st_q      <= ST_LOCKED;
              end
              CMD_CLOSE: begin
                pre_left_q <= trp_i - TW'(1);
                st_q       <= short_rp ? ST_IDLE : ST_PRECHG;
              end
              CMD_STOP: begin
                burst_left_q <= '0;
                st_q         <= ST_ACTIVE;
              end
              default: ;
            endcase
          end
        end
        ST_LOCKED: begin
          // internal precharge starts in the cycle the countdown reaches one
          if (ap_left_q <= BLW'(1)) begin
            pre_left_q <= trp_i - TW'(1);
            st_q       <= short_rp ? ST_IDLE : ST_PRECHG;
          end else begin
            ap_left_q <= ap_left_q - BLW'(1);
          end
        end
        ST_PRECHG: begin
          if (pre_left_q <= TW'(1)) st_q <= ST_IDLE;
          else pre_left_q <= pre_left_q - TW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_chk.sv
module sdram_bank_chk #(
  parameter int TW  = 4,
  parameter int BLW = 4,
  parameter int CLW = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic [2:0]     req_cmd_i,
  input logic [TW-1:0]  trcd_i,
  input logic [TW-1:0]  tras_i,
  input logic [TW-1:0]  trp_i,
  input logic [BLW-1:0] bl_i,
  input logic [CLW-1:0] cl_i,
  input logic           ready_o,
  input logic [2:0]     cmd_o,
  input logic [2:0]     state_o
);
  localparam int AW = ((TW > BLW) ? TW : BLW) + 3;

  logic [AW-1:0] since_open;
  logic          col_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_open <= '0;
    else if (cmd_o == 3'd1)      since_open <= AW'(1);
    else if (since_open != '1)   since_open <= since_open + AW'(1);
  end

  assign col_cmd = (cmd_o >= 3'd2) && (cmd_o <= 3'd5);

  p_open_from_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 3'd1 |-> state_o == 3'd0);
  p_open_activates_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 3'd1 |=> state_o == 3'd1);
  p_trcd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_cmd |-> since_open >= AW'(trcd_i));
  p_tras_close_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 3'd6 |-> since_open >= AW'(tras_i));
  p_stop_in_burst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == 3'd7 |-> state_o == 3'd2);
  p_locked_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 || state_o == 3'd4) |-> cmd_o == 3'd0);
  p_ap_tras_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 3'd3 && state_o != 3'd3) |-> $past(since_open) >= AW'(tras_i));
  p_held_nop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> cmd_o == 3'd0);
  p_echo_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (req_valid_i && cmd_o == req_cmd_i));

  logic unused_cfg;
  assign unused_cfg = ^{trp_i, bl_i, cl_i};
endmodule

bind sdram_bank_ctrl sdram_bank_chk #(.TW(TW), .BLW(BLW), .CLW(CLW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_cmd_i(req_cmd_i),
  .trcd_i(trcd_i), .tras_i(tras_i), .trp_i(trp_i), .bl_i(bl_i), .cl_i(cl_i),
  .ready_o(ready_o), .cmd_o(cmd_o), .state_o(state_o)
);

// File: tb/test_sdram_bank_ctrl.sv
module test_sdram_bank_ctrl;
  localparam int TW = 4, BLW = 4, CLW = 2;
  localparam int NOP = 0, OPEN = 1, RD = 2, WR = 3, RDA = 4, WRA = 5, CLOSE = 6, STOP = 7;
  localparam int S_IDLE = 0, S_ACT = 1, S_BURST = 2, S_LOCK = 3, S_PRE = 4;

  logic clk = 1'b0, rst_ni = 1'b0, req_valid_i = 1'b0;
  logic [2:0] req_cmd_i = '0;
  logic [TW-1:0] trcd_i, tras_i, trp_i;
  logic [BLW-1:0] bl_i;
  logic [CLW-1:0] cl_i;
  logic ready_o;
  logic [2:0] cmd_o, state_o;

  int checks = 0, errors = 0;
  int trcd, tras, trp, bl, cl;
  int n, mst, act_t, ev_t, ap_s;
  int last_state;
  bit done = 0;

  always #10 clk = ~clk;

  sdram_bank_ctrl #(.TW(TW), .BLW(BLW), .CLW(CLW)) i_sdram_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_cmd_i(req_cmd_i),
    .trcd_i(trcd_i), .tras_i(tras_i), .trp_i(trp_i), .bl_i(bl_i), .cl_i(cl_i),
    .ready_o(ready_o), .cmd_o(cmd_o), .state_o(state_o)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int ap_delay(int c);
    if (c == RDA) return (bl >= cl) ? bl - cl + 1 : 1;
    return bl;
  endfunction

  function automatic bit m_legal(int c);
    int age = n - act_t;
    bit open_row = (mst == S_ACT) || (mst == S_BURST);
    case (c)
      NOP:      return 1;
      OPEN:     return mst == S_IDLE;
      RD, WR:   return open_row && age >= trcd;
      RDA, WRA: return open_row && age >= trcd && age + ap_delay(c) >= tras;
      CLOSE:    return open_row && age >= tras;
      default:  return mst == S_BURST;
    endcase
  endfunction

  function automatic string cmd_tag(int c);
    case (c)
      OPEN: return "R2";  RD, WR: return "R3";  RDA, WRA: return "R10";
      CLOSE: return "R4"; STOP: return "R6";    default: return "R11";
    endcase
  endfunction

  function automatic string st_tag(int s);
    case (s)
      S_BURST: return "R5"; S_LOCK: return "R7"; S_PRE: return "R4";
      S_IDLE: return "R2";  default: return "R5";
    endcase
  endfunction

  // One cycle: drive, compare to model, advance model.
  task automatic cyc(bit v, int c);
    bit er, acc;
    int nxt;
    @(negedge clk);
    req_valid_i = v;
    req_cmd_i = 3'(c);
    #1;
    er = v && m_legal(c);
    last_state = int'(state_o);
    chk(state_o == 3'(mst), st_tag(mst), "state", int'(state_o), mst);
    chk(ready_o == er, cmd_tag(c), "ready", int'(ready_o), int'(er));
    chk(cmd_o == (er ? 3'(c) : 3'd0), "R11", "cmd", int'(cmd_o), er ? c : 0);
    acc = er && c != NOP;
    nxt = mst;
    case (mst)
      S_BURST: if (n + 1 >= ev_t) nxt = S_ACT;
      S_LOCK:  if (n == ap_s) begin nxt = (trp <= 1) ? S_IDLE : S_PRE; ev_t = n + trp; end
      S_PRE:   if (n + 1 >= ev_t) nxt = S_IDLE;
      default: ;
    endcase
    if (acc) case (c)
      OPEN:     begin nxt = S_ACT; act_t = n; end
      RD, WR:   begin nxt = (bl > 1) ? S_BURST : S_ACT; ev_t = n + bl; end
      RDA, WRA: begin nxt = S_LOCK; ap_s = n + ap_delay(c); end
      CLOSE:    begin nxt = (trp <= 1) ? S_IDLE : S_PRE; ev_t = n + trp; end
      STOP:     nxt = S_ACT;
      default:  ;
    endcase
    mst = nxt;
    n++;
  endtask

  task automatic do_reset(int rcd, int ras, int rp, int b, int l);
    @(negedge clk);
    rst_ni = 0; req_valid_i = 0; req_cmd_i = '0;
    trcd = rcd; tras = ras; trp = rp; bl = b; cl = l;
    trcd_i = TW'(rcd); tras_i = TW'(ras); trp_i = TW'(rp); bl_i = BLW'(b); cl_i = CLW'(l);
    repeat (2) @(negedge clk);
    rst_ni = 1;
    n = 0; mst = S_IDLE; act_t = -1000; ev_t = 0; ap_s = 0;
  endtask

  // Returns the number of cycles until the request was accepted.
  task automatic wait_accept(int c, output int k);
    k = 0;
    do begin
      cyc(1, c);
      k++;
    end while (cmd_o != 3'(c) && k < 64);
  endtask

  // Presents RD each cycle; counts cycles until idle is seen, expects it held throughout.
  task automatic until_idle(output int k);
    k = 0;
    do begin
      cyc(1, RD);
      k++;
      if (last_state != S_IDLE) chk(ready_o == 1'b0, "R9", "ready while locked", int'(ready_o), 0);
    end while (last_state != S_IDLE && k < 64);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int k;
    void'($urandom(32'h1234_5eed));

    // R1
    do_reset(2, 4, 2, 4, 2);
    #1;
    chk(state_o == 3'd0, "R1", "reset state", int'(state_o), 0);
    chk(cmd_o == 3'd0, "R1", "reset cmd", int'(cmd_o), 0);

    // R6: stop outside a burst is held
    cyc(1, STOP);
    chk(ready_o == 1'b0, "R6", "stop in idle ready", int'(ready_o), 0);

    // R10: one-beat self-closing read needs tRAS
    do_reset(1, 5, 2, 1, 1);
    wait_accept(OPEN, k);
    wait_accept(RDA, k);
    chk(k == 4, "R10", "rda offset", k, 4);
    until_idle(k);
    chk(k == 3, "R7", "idle after bl1 rda", k, 3);

    // R7: cl shortens the read close
    do_reset(2, 2, 3, 4, 3);
    wait_accept(OPEN, k);
    wait_accept(RDA, k);
    chk(k == 2, "R3", "rda after trcd", k, 2);
    until_idle(k);
    chk(k == 5, "R7", "idle after rda", k, 5);

    // R8: write close after last beat
    wait_accept(OPEN, k);
    chk(k == 1, "R2", "open after idle", k, 1);
    wait_accept(WRA, k);
    until_idle(k);
    chk(k == 7, "R8", "idle after wra", k, 7);

    // R6/R5: stop ends a plain burst
    do_reset(1, 2, 1, 8, 2);
    wait_accept(OPEN, k);
    wait_accept(RD, k);
    cyc(1, STOP);
    chk(ready_o == 1'b1, "R6", "stop in burst", int'(ready_o), 1);
    cyc(0, NOP);
    chk(last_state == S_ACT, "R6", "active after stop", last_state, S_ACT);

    // R4: close after tRAS, open after tRP
    do_reset(1, 3, 4, 2, 1);
    wait_accept(OPEN, k);
    wait_accept(CLOSE, k);
    chk(k == 3, "R4", "close offset", k, 3);
    wait_accept(OPEN, k);
    chk(k == 4, "R4", "open after close", k, 4);

    // Random configurations and traffic against the model
    for (int s = 0; s < 8; s++) begin
      int rcd = 1 + $urandom % 4;
      do_reset(rcd, rcd + $urandom % 6, 1 + $urandom % 4, 1 << ($urandom % 4), 1 + $urandom % 3);
      for (int i = 0; i < 600; i++) begin
        int c = $urandom % 8;
        if (mst == S_IDLE && ($urandom % 2) == 0) c = OPEN;
        cyc(($urandom % 4) != 0, c);
      end
    end

    summary();
  end
endmodule